// File: doc/BRIEF.md
# Immediate Shift Unit with Status Flags

This block shifts a 32-bit operand by a signed immediate count. The sign of the count gives the direction and its magnitude gives the distance. A positive count moves bits toward the most significant end. A negative count moves them toward the least significant end. A count of zero leaves the operand unchanged. For right shifts, a one-bit kind select chooses the fill: the operand's sign bit, or zeros. Left shifts always fill with zeros, whatever the kind.

Operations arrive on a valid/ready stream. The shifter itself is combinational. Its result and a five-bit status word are captured together into one output register, which drives a second valid/ready stream. A new operation is accepted whenever the output register is empty or is being emptied in the same cycle, so the unit sustains one operation per clock. When the consumer holds `out_ready` low, the result stays put and `in_ready` drops, which pushes back on the producer. The status bits describe the most recently accepted operation and keep that value until the next acceptance.

Top module: `imm_shift_unit`

## Requirements
- R1: A count of 0 returns the operand unchanged, for either kind.
- R2: A positive count n (1..31) gives the operand shifted toward the MSB by n with zeros entering at bit 0, for both kinds (e.g. 0x80000001 by +1 gives 0x00000002, by +31 gives 0x80000000).
- R3: With `in_kind`=0 (arithmetic), a negative count -n gives a right shift by n that replicates bit 31 (0x80000001 by -1 gives 0xC0000000, by -31 gives 0xFFFFFFFF).
- R4: With `in_kind`=1 (logical), a negative count -n gives a right shift by n that fills with zeros (0x80000001 by -1 gives 0x40000000, by -31 gives 0x00000001).
- R5: The count -32 shifts everything out: the result is all copies of bit 31 for arithmetic and zero for logical.
- R6: `st_zero` is 1 exactly when the result of the last accepted operation is all zeros (0 shifted by +1 sets it).
- R7: `st_neg` equals bit 31 of the result of the last accepted operation.
- R8: `st_carry`, `st_ovf0` and `st_ovf1` are 0 after every accepted operation, even when set bits are shifted out (0x80000001 by +31).
- R9: Synchronous reset clears `out_valid` and all status bits. Status bits change only in a cycle where `in_valid` and `in_ready` are both high.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and the status bits stay stable.
- R11: When a result is taken and a new operation is offered in the same cycle, the new operation is accepted in that cycle and its result appears on the next one, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_data | input | 32 | Operand |
| in_count | input | 6 | Signed shift count, two's complement |
| in_kind | input | 1 | Right-shift fill: 0 sign, 1 zero |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Shifted result |
| st_zero | output | 1 | Last result was zero |
| st_neg | output | 1 | Bit 31 of last result |
| st_carry | output | 1 | Carry status, cleared by shifts |
| st_ovf0 | output | 1 | First overflow status, cleared by shifts |
| st_ovf1 | output | 1 | Second overflow status, cleared by shifts |

## Verification
Two things can happen in the same cycle: the consumer drains the held result, and the output register loads a new operation together with its status word. The bench provokes this by stalling the consumer while an operand is waiting, then raising `out_ready` with the next operand still offered. It also runs back-to-back streams with the consumer always ready. It is judged correct when each result appears exactly once, in offer order, with status that matches that result and never the one before it. A full sweep of every count from -32 to +31, for both kinds, on corner and random operands, is compared with a reference model written from the requirements.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // right-shift fill selection, carried on in_kind
  typedef enum logic {
    SHK_ARITH = 1'b0,
    SHK_LOGIC = 1'b1
  } shift_kind_e;

  // status word captured with every accepted operation
  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf0;
    logic ovf1;
  } shf_flags_t;

  localparam shf_flags_t FLAGS_CLEAR = '{zero: 1'b0, neg: 1'b0, carry: 1'b0,
                                         ovf0: 1'b0, ovf1: 1'b0};

endpackage

// File: rtl/shf_count_decode.sv
module shf_count_decode #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count,
  output logic             go_left,
  output logic [CNT_W-1:0] magnitude
);

  logic             is_neg;
  logic [CNT_W-1:0] negated;

  assign is_neg  = count[CNT_W-1];
  assign negated = (~count) + {{(CNT_W-1){1'b0}}, 1'b1};

  // the most negative count maps to an unsigned magnitude of 2**(CNT_W-1)
  always_comb begin
    go_left   = !is_neg && (count != '0);
    magnitude = is_neg ? negated : count;
  end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int DW    = 32,
  parameter int CNT_W = 6
) (
  input  logic [DW-1:0]    operand,
  input  logic [CNT_W-1:0] magnitude,
  input  logic             go_left,
  input  logic             fill_bit,
  output logic [DW-1:0]    result
);

  logic [DW-1:0] mirrored_in;
  logic [DW-1:0] stage_q [CNT_W+1];

  // a left shift is a right shift of the bit-reversed word
  generate
    for (genvar b = 0; b < DW; b++) begin : g_mirror_in
      assign mirrored_in[b] = go_left ? operand[DW-1-b] : operand[b];
    end
  endgenerate

  assign stage_q[0] = mirrored_in;

  generate
    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      if (STEP >= DW) begin : g_flush
        assign stage_q[s+1] = magnitude[s] ? {DW{fill_bit}} : stage_q[s];
      end else begin : g_move
        assign stage_q[s+1] = magnitude[s] ?
                              {{STEP{fill_bit}}, stage_q[s][DW-1:STEP]} :
                              stage_q[s];
      end
    end
  endgenerate

  generate
    for (genvar b = 0; b < DW; b++) begin : g_mirror_out
      assign result[b] = go_left ? stage_q[CNT_W][DW-1-b] : stage_q[CNT_W][b];
    end
  endgenerate

endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
  import shf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] result,
  output shf_flags_t    flags
);

  // immediate shifts report neither carry nor overflow
  always_comb begin
    flags       = FLAGS_CLEAR;
    flags.zero  = (result == '0);
    flags.neg   = result[DW-1];
    flags.carry = 1'b0;
    flags.ovf0  = 1'b0;
    flags.ovf1  = 1'b0;
  end

endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage
  import shf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] next_data,
  input  shf_flags_t    next_flags,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output shf_flags_t    flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      flags_q   <= FLAGS_CLEAR;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= next_data;
      flags_q   <= next_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
  import shf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [CNT_W-1:0] in_count,
  input  logic             in_kind,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             st_zero,
  output logic             st_neg,
  output logic             st_carry,
  output logic             st_ovf0,
  output logic             st_ovf1
);

  logic             go_left;
  logic [CNT_W-1:0] magnitude;
  logic             fill_bit;
  logic [DW-1:0]    shifted;
  shf_flags_t       next_flags;
  shf_flags_t       flags_q;
  logic             take;

  shf_count_decode #(.CNT_W(CNT_W)) u_decode (
    .count     (in_count),
    .go_left   (go_left),
    .magnitude (magnitude)
  );

  assign fill_bit = !go_left && (shift_kind_e'(in_kind) == SHK_ARITH) && in_data[DW-1];

  shf_barrel #(.DW(DW), .CNT_W(CNT_W)) u_barrel (
    .operand   (in_data),
    .magnitude (magnitude),
    .go_left   (go_left),
    .fill_bit  (fill_bit),
    .result    (shifted)
  );

  shf_flag_gen #(.DW(DW)) u_flags (
    .result (shifted),
    .flags  (next_flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  shf_out_stage #(.DW(DW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .next_data  (shifted),
    .next_flags (next_flags),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .flags_q    (flags_q)
  );

  assign st_zero  = flags_q.zero;
  assign st_neg   = flags_q.neg;
  assign st_carry = flags_q.carry;
  assign st_ovf0  = flags_q.ovf0;
  assign st_ovf1  = flags_q.ovf1;

endmodule

// File: rtl/imm_shift_unit_chk.sv
module imm_shift_unit_chk #(
  parameter int DW    = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    in_data,
  input logic [CNT_W-1:0] in_count,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             st_zero,
  input logic             st_neg,
  input logic             st_carry,
  input logic             st_ovf0,
  input logic             st_ovf1
);

  logic [4:0] st_vec;
  assign st_vec = {st_zero, st_neg, st_carry, st_ovf0, st_ovf1};

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (st_zero == (out_data == '0))); // R6

  AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (st_neg == out_data[DW-1])); // R7

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(st_vec)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R11

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_count == '0) |=> (out_data == $past(in_data))); // R1

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!st_carry && !st_ovf0 && !st_ovf1)); // R8

endmodule

bind imm_shift_unit imm_shift_unit_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_count  (in_count),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .st_zero   (st_zero),
  .st_neg    (st_neg),
  .st_carry  (st_carry),
  .st_ovf0   (st_ovf0),
  .st_ovf1   (st_ovf1)
);

// File: tb/imm_shift_unit_bench.sv
`timescale 1ns/1ps
module imm_shift_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [5:0]  in_count = '0;
  logic        in_kind = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        st_zero, st_neg, st_carry, st_ovf0, st_ovf1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  imm_shift_unit u_imm_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_count(in_count), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .st_zero(st_zero), .st_neg(st_neg), .st_carry(st_carry),
    .st_ovf0(st_ovf0), .st_ovf1(st_ovf1)
  );

  // reference: count >= 0 shifts left, otherwise right with kind-chosen fill
  function automatic logic [31:0] ref_shift(logic [31:0] d, int c, bit logical);
    if (c >= 0) return d << c;
    if (logical) return d >> (-c);
    return 32'($signed(d) >>> (-c));
  endfunction

  function automatic logic [4:0] ref_flags(logic [31:0] r);
    return {r == 32'h0, r[31], 3'b000};
  endfunction

  function automatic logic [4:0] st_now();
    return {st_zero, st_neg, st_carry, st_ovf0, st_ovf1};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation with the consumer ready; checks result and status
  task automatic run_op(string tag, logic [31:0] d, int c, bit logical);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_count = 6'(c); in_kind = logical;
    @(negedge clk);
    in_valid = 1'b0;
    exp = ref_shift(d, c, logical);
    check({tag, " data"}, out_data, exp);
    check({tag, " status"}, {27'b0, st_now()}, {27'b0, ref_flags(exp)});
  endtask

  task automatic t_reset();
    check("R9 reset out_valid", {31'b0, out_valid}, 32'h0);
    check("R9 reset status", {27'b0, st_now()}, 32'h0);
    check("R10 reset in_ready", {31'b0, in_ready}, 32'h1);
  endtask

  task automatic t_stated_points();
    run_op("R2 +1", 32'h80000001, 1, 1'b0);
    run_op("R2 +1 logical", 32'h80000001, 1, 1'b1);
    run_op("R2 R8 +31", 32'h80000001, 31, 1'b0);
    check("R8 carry/ovf after discard", {29'b0, st_carry, st_ovf0, st_ovf1}, 32'h0);
    run_op("R3 -1", 32'h80000001, -1, 1'b0);
    run_op("R3 -31", 32'h80000001, -31, 1'b0);
    run_op("R4 -1", 32'h80000001, -1, 1'b1);
    run_op("R4 -31", 32'h80000001, -31, 1'b1);
    run_op("R6 zero by +1", 32'h0, 1, 1'b0);
    check("R6 zero flag set", {31'b0, st_zero}, 32'h1);
    run_op("R7 negative", 32'h40000000, 1, 1'b0);
    check("R7 neg flag set", {31'b0, st_neg}, 32'h1);
    run_op("R1 zero count", 32'h80000001, 0, 1'b0);
    run_op("R5 -32 arith", 32'h80000001, -32, 1'b0);
    run_op("R5 -32 logical", 32'h80000001, -32, 1'b1);
  endtask

  task automatic t_sweep();
    logic [31:0] ops [8];
    ops[0] = 32'h80000001; ops[1] = 32'h00000000; ops[2] = 32'hFFFFFFFF;
    ops[3] = 32'h7FFFFFFF; ops[4] = 32'hA5A5A5A5;
    for (int i = 5; i < 8; i++) ops[i] = $urandom;
    for (int k = 0; k < 2; k++)
      for (int o = 0; o < 8; o++)
        for (int c = -32; c <= 31; c++)
          run_op("R1 R2 R3 R4 R5 sweep", ops[o], c, k[0]);
  endtask

  // stall, hold, then hand-off and acceptance in one cycle
  task automatic t_stall_overlap();
    logic [31:0] ea, eb;
    logic [4:0]  fa;
    ea = ref_shift(32'h80000001, -31, 1'b0);
    eb = ref_shift(32'h00000003, 4, 1'b1);
    fa = ref_flags(ea);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'h80000001; in_count = 6'(-31); in_kind = 1'b0;
    @(negedge clk);
    in_data = 32'h00000003; in_count = 6'd4; in_kind = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R10 stall in_ready low", {31'b0, in_ready}, 32'h0);
      check("R10 stall data held", out_data, ea);
      check("R9 stall status held", {27'b0, st_now()}, {27'b0, fa});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 overlap valid", {31'b0, out_valid}, 32'h1);
    check("R11 overlap data", out_data, eb);
    check("R11 overlap status", {27'b0, st_now()}, {27'b0, ref_flags(eb)});
    @(negedge clk);
    check("R10 drained", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    check("R9 idle status held", {27'b0, st_now()}, {27'b0, ref_flags(eb)});
  endtask

  task automatic t_back_to_back();
    logic [31:0] d [4];
    int          c [4];
    d[0] = 32'h00000000; c[0] = 5;
    d[1] = 32'hF0000000; c[1] = -4;
    d[2] = 32'h12345678; c[2] = 0;
    d[3] = 32'h00000001; c[3] = 31;
    out_ready = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_data = d[i]; in_count = 6'(c[i]); in_kind = 1'b0;
      @(negedge clk);
      check("R11 stream data", out_data, ref_shift(d[i], c[i], 1'b0));
      check("R11 stream status", {27'b0, st_now()},
            {27'b0, ref_flags(ref_shift(d[i], c[i], 1'b0))});
    end
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stated_points();
    t_stall_overlap();
    t_back_to_back();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule